// File: doc/BRIEF.md
# Multi-Mode Lookup-Table Slice

This block is a configurable logic cell built from two 16-entry truth tables, called table A and table B. The same two tables serve three uses, chosen by a static mode field.

- **Logic mode.** The tables evaluate any function of four inputs each. The pair can also act as one 5-input function: a fifth input picks between the two tables, which then share the A-side inputs.
- **ROM mode.** The tables act as two independent 16x1 read-only memories.
- **RAM mode.** The tables act as one 16x2 single-port memory. Reads are combinational and the write is synchronous.

Contents are placed through a parallel load port before normal use. The `HAS_RAM` parameter builds a variant without the write path. In that variant the RAM code falls back to ROM behaviour and write requests have no effect.

Top module: `lut_slice`

## Requirements
- R1: An active-low asynchronous reset clears both tables, so every output reads 0 after reset.
- R2: When `cfg_ld` is high at a rising edge, `cfg_word` replaces table A if `cfg_tgt` is 0, or table B if `cfg_tgt` is 1. A load takes priority over a RAM write in the same cycle.
- R3: With `mode` = 2'b00 (logic), `out_a` is bit `in_a` of table A and `out_b` is bit `in_b` of table B. Bit n of a table is the entry for input value n.
- R4: In logic mode, `out_5` is bit `in_a` of table B when `in_x` is 1, and bit `in_a` of table A when `in_x` is 0.
- R5: `mode` = 2'b11 is reserved and gives outputs identical to logic mode.
- R6: With `mode` = 2'b01 (ROM), `out_a` is A[`in_a`], `out_b` is B[`in_b`] and `out_5` is 0.
- R7: With `mode` = 2'b10 (RAM, `HAS_RAM` = 1), both outputs read address `in_a`: `out_a` is A[`in_a`] and `out_b` is B[`in_a`]. `out_5` is 0 and `in_b` is ignored.
- R8: In RAM mode with `wr_en` high and no load, the rising edge writes `wr_bits[0]` to A[`in_a`] and `wr_bits[1]` to B[`in_a`]. The new value is visible on the outputs right after that edge.
- R9: `wr_en` has no effect in any mode other than 2'b10.
- R10: With `HAS_RAM` = 0, `mode` 2'b10 behaves as ROM mode and `wr_en` never changes a table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ld | input | 1 | Load enable for a whole table |
| cfg_tgt | input | 1 | Table chosen for the load (0 = A, 1 = B) |
| cfg_word | input | 16 | Truth-table word to load |
| mode | input | 2 | 00 logic, 01 ROM, 10 RAM, 11 same as logic |
| in_a | input | 4 | A-side inputs, also the RAM address |
| in_b | input | 4 | B-side inputs |
| in_x | input | 1 | Fifth input for the 5-input function |
| wr_en | input | 1 | RAM write enable |
| wr_bits | input | 2 | RAM write data (bit 0 to A, bit 1 to B) |
| out_a | output | 1 | Table A output |
| out_b | output | 1 | Table B output |
| out_5 | output | 1 | 5-input function output |

## Verification
The bench drives a default slice and a RAM-less slice side by side. It targets several corner cases:

- A load and a RAM write in the same cycle. A design with the wrong priority would show the written bit instead of the loaded word.
- Write enables raised in ROM mode. These expose a write path that is not gated by mode, because the stored bit would change.
- RAM mode. Here `out_b` must follow `in_a`. Routing `in_b` through would give B-side reads at the wrong address.
- The reserved mode code and the RAM-less variant. These catch decoders that fall through to the wrong behaviour.

Long random runs compare all three outputs of both slices against a behavioural model on every clock.

// File: rtl/lut_slice.sv
module lut_slice #(
  parameter bit HAS_RAM = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_ld,
  input  logic        cfg_tgt,
  input  logic [15:0] cfg_word,
  input  logic [1:0]  mode,
  input  logic [3:0]  in_a,
  input  logic [3:0]  in_b,
  input  logic        in_x,
  input  logic        wr_en,
  input  logic [1:0]  wr_bits,
  output logic        out_a,
  output logic        out_b,
  output logic        out_5
);
  logic [15:0] tt_a, tt_b;
  logic        ram_mode, rom_mode, logic_mode, do_wr;
  logic [3:0]  idx_b;

  assign ram_mode   = HAS_RAM && (mode == 2'b10);
  assign rom_mode   = (mode == 2'b01) || (!HAS_RAM && mode == 2'b10);
  assign logic_mode = !ram_mode && !rom_mode;

  generate
    if (HAS_RAM) begin : g_wr
      assign do_wr = ram_mode && wr_en && !cfg_ld;
    end else begin : g_nowr
      assign do_wr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tt_a <= '0;
      tt_b <= '0;
    end else if (cfg_ld) begin
      if (cfg_tgt) tt_b <= cfg_word;
      else         tt_a <= cfg_word;
    end else if (do_wr) begin
      tt_a[in_a] <= wr_bits[0];
      tt_b[in_a] <= wr_bits[1];
    end
  end

  assign idx_b = ram_mode ? in_a : in_b;
  assign out_a = tt_a[in_a];
  assign out_b = tt_b[idx_b];
  assign out_5 = logic_mode && (in_x ? tt_b[in_a] : tt_a[in_a]);
endmodule

module lut_slice_chk #(
  parameter bit HAS_RAM = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_ld,
  input logic        cfg_tgt,
  input logic [15:0] cfg_word,
  input logic [1:0]  mode,
  input logic [3:0]  in_a,
  input logic        wr_en,
  input logic [1:0]  wr_bits,
  input logic        out_5,
  input logic [15:0] tt_a,
  input logic [15:0] tt_b
);
  // R2
  load_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ld && !cfg_tgt |=> tt_a == $past(cfg_word));
  // R2
  load_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ld && cfg_tgt |=> tt_b == $past(cfg_word));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ld && !(wr_en && mode == 2'b10) |=> $stable(tt_a) && $stable(tt_b));
  // R6
  f5_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 || mode == 2'b10) |-> !out_5);

  generate
    if (HAS_RAM) begin : g_ram
      // R8
      ram_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ld && wr_en && mode == 2'b10 |=>
          tt_a[$past(in_a)] == $past(wr_bits[0]) && tt_b[$past(in_a)] == $past(wr_bits[1]));
    end else begin : g_noram
      // R10
      no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ld |=> $stable(tt_a) && $stable(tt_b));
    end
  endgenerate
endmodule

bind lut_slice lut_slice_chk #(.HAS_RAM(HAS_RAM)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ld(cfg_ld), .cfg_tgt(cfg_tgt), .cfg_word(cfg_word),
  .mode(mode), .in_a(in_a), .wr_en(wr_en), .wr_bits(wr_bits), .out_5(out_5),
  .tt_a(tt_a), .tt_b(tt_b)
);

// File: tb/sim_lut_slice.sv
`timescale 1ns/1ps
module sim_lut_slice;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_ld = 0, cfg_tgt = 0, in_x = 0, wr_en = 0;
  logic [15:0] cfg_word = '0;
  logic [1:0] mode = 0, wr_bits = 0;
  logic [3:0] in_a = 0, in_b = 0;
  logic oa0, ob0, o50, oa1, ob1, o51;
  int errors = 0, checks = 0;
  logic [15:0] ma = 0, mb = 0, na = 0, nb = 0;

  always #4 clk = ~clk;

  lut_slice u0 (.clk(clk), .rst_n(rst_n), .cfg_ld(cfg_ld), .cfg_tgt(cfg_tgt),
    .cfg_word(cfg_word), .mode(mode), .in_a(in_a), .in_b(in_b), .in_x(in_x),
    .wr_en(wr_en), .wr_bits(wr_bits), .out_a(oa0), .out_b(ob0), .out_5(o50));
  lut_slice #(.HAS_RAM(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .cfg_ld(cfg_ld), .cfg_tgt(cfg_tgt),
    .cfg_word(cfg_word), .mode(mode), .in_a(in_a), .in_b(in_b), .in_x(in_x),
    .wr_en(wr_en), .wr_bits(wr_bits), .out_a(oa1), .out_b(ob1), .out_5(o51));

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b (mode=%b a=%h b=%h x=%b)",
               req, what, act, exp, mode, in_a, in_b, in_x);
    end
  endtask

  task automatic compare(bit ram, logic [15:0] ta, logic [15:0] tb,
                         logic a, logic b, logic f, string tag);
    bit rm, ro;
    string t;
    logic ea, eb, e5;
    rm = ram && mode == 2'b10;
    ro = mode == 2'b01 || (!ram && mode == 2'b10);
    ea = ta[in_a];
    eb = rm ? tb[in_a] : tb[in_b];
    e5 = (!rm && !ro) ? (in_x ? tb[in_a] : ta[in_a]) : 1'b0;
    if (tag != "") t = tag;
    else if (!ram && mode == 2'b10) t = "R10";
    else case (mode)
      2'b00: t = "R3";
      2'b01: t = "R6";
      2'b10: t = "R7";
      default: t = "R5";
    endcase
    chk(t, "out_a", a, ea);
    chk(t, "out_b", b, eb);
    chk((mode == 2'b00 && tag == "") ? "R4" : t, "out_5", f, e5);
  endtask

  task automatic step(logic [1:0] m, logic [3:0] ia, logic [3:0] ib, logic x,
                      logic we, logic [1:0] wb, logic ld, logic tg,
                      logic [15:0] w, string tag);
    @(negedge clk);
    mode = m; in_a = ia; in_b = ib; in_x = x; wr_en = we; wr_bits = wb;
    cfg_ld = ld; cfg_tgt = tg; cfg_word = w;
    #1;
    compare(1'b1, ma, mb, oa0, ob0, o50, tag);
    compare(1'b0, na, nb, oa1, ob1, o51, tag);
    @(posedge clk);
    if (ld) begin
      if (tg) begin mb = w; nb = w; end
      else    begin ma = w; na = w; end
    end else if (we && m == 2'b10) begin
      ma[ia] = wb[0];
      mb[ia] = wb[1];
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: outputs zero while and after reset
    #3;
    for (int i = 0; i < 4; i++) begin
      in_a = 4'(i * 5); in_b = 4'(15 - i); in_x = i[0]; mode = 2'(i);
      #1;
      chk("R1", "out_a", oa0, 1'b0); chk("R1", "out_b", ob0, 1'b0);
      chk("R1", "out_5", o50, 1'b0); chk("R1", "out_a nr", oa1, 1'b0);
    end
    @(negedge clk); rst_n = 1'b1;
    step(2'b00, 4'h0, 4'h4, 0, 0, 2'b00, 1, 0, 16'hA5C3, "R1");
    step(2'b00, 4'h1, 4'h4, 1, 0, 2'b00, 1, 1, 16'h0FF0, "R2");
    step(2'b00, 4'h6, 4'h4, 1, 0, 2'b00, 0, 0, 16'h0000, "R2");
    // R2: load beats write in the same cycle
    step(2'b10, 4'h2, 4'h0, 0, 1, 2'b11, 1, 0, 16'h1234, "");
    step(2'b10, 4'h2, 4'h0, 0, 0, 2'b00, 0, 0, 16'h0000, "R2");
    // R9: write attempt in ROM and logic modes
    step(2'b01, 4'h5, 4'h5, 0, 1, 2'b00, 0, 0, 16'h0000, "");
    step(2'b00, 4'h5, 4'h5, 0, 1, 2'b00, 0, 0, 16'h0000, "");
    step(2'b01, 4'h5, 4'h5, 1, 0, 2'b00, 0, 0, 16'h0000, "R9");
    // R8 R10: RAM write then read
    step(2'b10, 4'h9, 4'h3, 0, 1, 2'b01, 0, 0, 16'h0000, "");
    step(2'b10, 4'h9, 4'h3, 0, 0, 2'b00, 0, 0, 16'h0000, "R8 R10");
    step(2'b10, 4'h2, 4'h3, 0, 1, 2'b10, 0, 0, 16'h0000, "");
    step(2'b10, 4'h2, 4'h7, 1, 0, 2'b00, 0, 0, 16'h0000, "R8 R10");
    step(2'b11, 4'hC, 4'h7, 1, 0, 2'b00, 0, 0, 16'h0000, "R5");
    for (int n = 0; n < 4000; n++) begin
      logic ld;
      ld = ($urandom % 16) == 0;
      step(2'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), ld, 1'($urandom), 16'($urandom), "");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule